// File: doc/BRIEF.md
# Drop-Oldest Command Queue with Paced Drain

This block buffers fire-and-forget commands for one subsystem before they go out on a serial link. The far end acknowledges no individual command, so the queue never applies back-pressure to its writer. When the queue is full, a new command overwrites the oldest waiting one. Each such eviction raises a one-cycle drop strobe and advances a drop counter.

The drain side issues at most one command per spacing interval. The nominal interval, counted in clock cycles, is the wire time of one short frame. An overflow notification (or a NACK) from the far end starts a hold window of programmable length. During that window the spacing stretches to five quarters of nominal, which gives 80% of the nominal command rate. A further notification inside the window restarts it. While the degraded input is high, nothing is dequeued, but the queue keeps accepting commands under the same drop-oldest rule. One instance is used per subsystem.

Top module: `cmdq_pacer`

## Requirements
- R1: After reset, `occupancy` is 0, `out_valid` is 0, `drop_count` is 0, `drop_strobe` is 0 and `throttled` is 0.
- R2: Commands leave in the order they were accepted. A dequeue shows as a one-cycle `out_valid` pulse with the command on `out_data`. No dequeue occurs while `occupancy` is 0.
- R3: A push into a full queue with no dequeue in that cycle evicts the oldest entry and accepts the new one. `occupancy` stays at DEPTH.
- R4: For each eviction, `drop_strobe` is high for exactly one cycle, in the cycle that follows the push. In that same cycle `drop_count` is one higher than before, wrapping modulo 2^DROP_W.
- R5: A push and a dequeue in the same cycle on a full queue evict nothing, leave `drop_count` unchanged and keep `occupancy` at DEPTH.
- R6: While not throttled, successive `out_valid` pulses are never closer than NOM_GAP cycles apart. With a backlog they are exactly NOM_GAP apart. After an idle gap of at least that length, the first queued entry leaves without delay.
- R7: `ovf_evt` high in a cycle makes `throttled` high from the next cycle, for exactly HOLD_CYCLES cycles. While `throttled` is high, the spacing between dequeues is ceil(5*NOM_GAP/4) cycles.
- R8: `ovf_evt` arriving while `throttled` is already high restarts the window, so `throttled` stays high for HOLD_CYCLES cycles counted from the new event.
- R9: While `degraded_in` is high, no `out_valid` pulse follows, and pushes are still accepted under R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Push a command this cycle |
| cmd_data | input | DATA_W | Command word to push |
| ovf_evt | input | 1 | Overflow notification or NACK from the far end |
| degraded_in | input | 1 | Link degraded: stop dequeuing |
| out_valid | output | 1 | One-cycle pulse: a command is leaving |
| out_data | output | DATA_W | Command leaving the queue |
| occupancy | output | $clog2(DEPTH+1) | Entries currently held |
| drop_strobe | output | 1 | One-cycle pulse per evicted entry |
| drop_count | output | DROP_W | Running count of evictions (wraps) |
| throttled | output | 1 | Reduced drain rate is in force |

## Verification
The hardest case to reach from the ports is a push landing in exactly the cycle a full queue dequeues. The stimulus first fills the queue with `degraded_in` held high, and waits until the spacing counter has run out. It then drops `degraded_in` and pushes in the same cycle. The next cycle must show a dequeue, no drop strobe and an unchanged count. The overflow window restart is reached by sending a second notification partway through a running window and timing the remaining high stretch of `throttled`.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  // Spacing that gives 80% of the nominal rate, rounded up.
  function automatic int slow_gap(input int nom);
    return (nom * 5 + 3) / 4;
  endfunction
endpackage

// File: rtl/cmdq_ring.sv
module cmdq_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [OCC_W-1:0]  count_o,
  output logic              drop_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [OCC_W-1:0]  count_q;
  logic              full;

  assign full    = (count_q == OCC_W'(DEPTH));
  assign drop_o  = push_i && full && !pop_i;
  assign count_o = count_q;

  // storage: write port and registered read port, no reset
  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= data_i;
    if (pop_i)  data_o    <= mem[rd_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_i)          wr_q <= wr_q + 1'b1;
      if (pop_i || drop_o) rd_q <= rd_q + 1'b1;
      if (push_i && !pop_i && !full) count_q <= count_q + 1'b1;
      else if (pop_i && !push_i)     count_q <= count_q - 1'b1;
    end
  end

  // R2
  never_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> (count_q != '0));
  // R3
  drop_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    drop_o |=> (count_q == OCC_W'(DEPTH)));
  // R5
  swap_keeps_full_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && full) |=> (count_q == OCC_W'(DEPTH)));
endmodule

// File: rtl/cmdq_gap.sv
module cmdq_gap #(
  parameter int NOM_GAP = 8,
  localparam int SLOW_GAP = cmdq_pkg::slow_gap(NOM_GAP),
  localparam int GW = $clog2(SLOW_GAP + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic throttle_i,
  input  logic pop_i,
  output logic ready_o
);
  logic [GW-1:0] gap_q;
  logic [GW-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst)                          gap_q <= GW'(SLOW_GAP);
    else if (pop_i)                   gap_q <= '0;
    else if (gap_q != GW'(SLOW_GAP))  gap_q <= gap_q + 1'b1;
  end

  assign limit   = throttle_i ? GW'(SLOW_GAP - 1) : GW'(NOM_GAP - 1);
  assign ready_o = (gap_q >= limit);

  // R6
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |=> !ready_o);
endmodule

// File: rtl/cmdq_hold.sv
module cmdq_hold #(
  parameter int HOLD_CYCLES = 64,
  localparam int HW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic event_i,
  output logic active_o
);
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)                 hold_q <= '0;
    else if (event_i)        hold_q <= HW'(HOLD_CYCLES);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign active_o = (hold_q != '0);

  // R7
  event_arms_chk: assert property (@(posedge clk) disable iff (rst)
    event_i |=> active_o);
  // R8
  event_rearms_chk: assert property (@(posedge clk) disable iff (rst)
    event_i |=> (hold_q == HW'(HOLD_CYCLES)));
endmodule

// File: rtl/cmdq_pacer.sv
module cmdq_pacer #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 8,
  parameter int NOM_GAP     = 8,
  parameter int HOLD_CYCLES = 64,
  parameter int DROP_W      = 8,
  localparam int OCC_W      = $clog2(DEPTH + 1),
  localparam int SLOW_GAP   = cmdq_pkg::slow_gap(NOM_GAP),
  localparam int SW         = $clog2(SLOW_GAP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              ovf_evt,
  input  logic              degraded_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [OCC_W-1:0]  occupancy,
  output logic              drop_strobe,
  output logic [DROP_W-1:0] drop_count,
  output logic              throttled
);
  logic gap_ready, pop, drop;

  assign pop = (occupancy != '0) && !degraded_in && gap_ready;

  cmdq_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) ring_i (
    .clk(clk), .rst(rst), .push_i(cmd_valid), .data_i(cmd_data),
    .pop_i(pop), .data_o(out_data), .count_o(occupancy), .drop_o(drop));

  cmdq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk(clk), .rst(rst), .event_i(ovf_evt), .active_o(throttled));

  cmdq_gap #(.NOM_GAP(NOM_GAP)) gap_i (
    .clk(clk), .rst(rst), .throttle_i(throttled), .pop_i(pop),
    .ready_o(gap_ready));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      drop_strobe <= 1'b0;
      drop_count  <= '0;
    end else begin
      out_valid   <= pop;
      drop_strobe <= drop;
      if (drop) drop_count <= drop_count + 1'b1;
    end
  end

  // independent spacing observer for the output pulses
  logic [SW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)                          since_q <= SW'(SLOW_GAP);
    else if (out_valid)               since_q <= SW'(1);
    else if (since_q != SW'(SLOW_GAP)) since_q <= since_q + 1'b1;
  end

  // R6
  out_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since_q >= SW'(NOM_GAP)));
  // R9
  degraded_stall_chk: assert property (@(posedge clk) disable iff (rst)
    degraded_in |=> !out_valid);
  // R4
  drop_tally_chk: assert property (@(posedge clk) disable iff (rst)
    drop_strobe |-> (drop_count == DROP_W'($past(drop_count) + 1'b1)));
endmodule

// File: tb/cmdq_pacer_tb.sv
module cmdq_pacer_tb_top;
  localparam int DATA_W = 8, DEPTH = 8, NOM_GAP = 8, HOLD = 64, DROP_W = 8;
  localparam int SLOW_GAP = (NOM_GAP * 5 + 3) / 4;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, ovf_evt = 0, degraded_in = 0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic out_valid, drop_strobe, throttled;
  logic [DATA_W-1:0] out_data;
  logic [$clog2(DEPTH+1)-1:0] occupancy;
  logic [DROP_W-1:0] drop_count;

  always #4 clk = ~clk;  // 125 MHz

  cmdq_pacer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NOM_GAP(NOM_GAP),
               .HOLD_CYCLES(HOLD), .DROP_W(DROP_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .ovf_evt(ovf_evt), .degraded_in(degraded_in), .out_valid(out_valid),
    .out_data(out_data), .occupancy(occupancy), .drop_strobe(drop_strobe),
    .drop_count(drop_count), .throttled(throttled));

  int checks = 0, fails = 0;
  int cyc = 0, last_out = -1, min_gap = 1 << 30, strobes = 0;
  logic [DATA_W-1:0] expq[$];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && drop_strobe) strobes++;
    if (!rst && out_valid) begin
      if (expq.size() == 0) chk(0, "R2", "unexpected dequeue", out_data, -1);
      else begin
        logic [DATA_W-1:0] e;
        e = expq.pop_front();
        chk(out_data == e, "R2", "dequeued data", out_data, e);
      end
      if (last_out >= 0 && cyc - last_out < min_gap) min_gap = cyc - last_out;
      last_out = cyc;
    end
  end

  task automatic push(input logic [DATA_W-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_data = d;
    if (degraded_in && expq.size() == DEPTH) void'(expq.pop_front());
    expq.push_back(d);
  endtask

  task automatic idle(input int n);
    @(negedge clk); cmd_valid = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drain();
    int n = 0;
    last_out = -1; min_gap = 1 << 30;
    degraded_in = 0;
    while (expq.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk(occupancy == 0, "R2", "empty after drain", occupancy, 0);
  endtask

  task automatic pulse_ovf();
    @(negedge clk); ovf_evt = 1;
    @(negedge clk); ovf_evt = 0;
  endtask

  function automatic int high_run_fn(); return 0; endfunction

  initial begin
    int run;
    int dc;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(occupancy == 0, "R1", "occupancy", occupancy, 0);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(drop_count == 0, "R1", "drop_count", drop_count, 0);
    chk(drop_strobe == 0, "R1", "drop_strobe", drop_strobe, 0);
    chk(throttled == 0, "R1", "throttled", throttled, 0);

    // R9: stall while degraded, pushes still taken
    degraded_in = 1;
    for (int i = 0; i < 3; i++) push(8'h10 + 8'(i));
    idle(20);
    chk(occupancy == 3, "R9", "held while degraded", occupancy, 3);
    // R2 / R6: order and nominal spacing
    drain();
    chk(min_gap == NOM_GAP, "R6", "nominal spacing", min_gap, NOM_GAP);

    // R3 / R4 / R9: overfill while degraded
    degraded_in = 1;
    for (int i = 0; i < DEPTH + 3; i++) push(8'h40 + 8'(i));
    idle(3);
    chk(occupancy == DEPTH, "R3", "occupancy stays full", occupancy, DEPTH);
    chk(drop_count == 3, "R4", "drop_count", drop_count, 3);
    chk(strobes == 3, "R4", "drop strobes seen", strobes, 3);
    drain();   // oldest three must be gone (R3 via scoreboard)
    chk(min_gap == NOM_GAP, "R6", "backlog spacing", min_gap, NOM_GAP);

    // R7: throttled spacing
    pulse_ovf();
    chk(throttled == 1, "R7", "throttled after event", throttled, 1);
    degraded_in = 1;
    for (int i = 0; i < 4; i++) push(8'h80 + 8'(i));
    idle(2);
    drain();
    chk(min_gap == SLOW_GAP, "R7", "throttled spacing", min_gap, SLOW_GAP);
    run = 0;
    while (throttled && run < 1000) begin @(negedge clk); run++; end

    // R7: window length
    pulse_ovf();
    run = 0;
    while (throttled && run < 1000) begin @(negedge clk); run++; end
    chk(run == HOLD, "R7", "window length", run, HOLD);

    // R8: restart inside the window
    pulse_ovf();
    repeat (40) @(negedge clk);
    chk(throttled == 1, "R8", "still throttled mid-window", throttled, 1);
    pulse_ovf();
    run = 0;
    while (throttled && run < 1000) begin @(negedge clk); run++; end
    chk(run == HOLD, "R8", "restarted window length", run, HOLD);

    // R5: push in the very cycle a full queue dequeues
    degraded_in = 1;
    for (int i = 0; i < DEPTH; i++) push(8'hC0 + 8'(i));
    idle(SLOW_GAP + 2);
    dc = drop_count;
    @(negedge clk);
    degraded_in = 0; cmd_valid = 1; cmd_data = 8'h55; expq.push_back(8'h55);
    @(negedge clk);
    cmd_valid = 0; degraded_in = 1;
    chk(out_valid == 1, "R5", "dequeue in swap cycle", out_valid, 1);
    chk(drop_strobe == 0, "R5", "no drop on swap", drop_strobe, 0);
    chk(occupancy == DEPTH, "R5", "occupancy on swap", occupancy, DEPTH);
    chk(drop_count == dc, "R5", "drop_count on swap", drop_count, dc);
    drain();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule